// File: doc/BRIEF.md
# Two-Round SHA-1 Compression Core

This block runs the SHA-1 compression function over one 512-bit message block that the caller has already padded. It performs two of the eighty steps in each clock cycle. A look-ahead stage works beside the step logic and prepares three partial sums for the next double-step. As a result, the step datapath only has to add the pre-summed terms onto the rotated working words.

A block is accepted by a one-cycle start strobe while the core is idle. The first busy cycle only seeds the look-ahead sums from the starting state and the first message words. Forty double-step cycles follow. When the last one completes, the five working words are added to the starting chaining words, and `done_o` pulses.

The chain control selects the starting words:
- With chaining off, the core starts from the standard SHA-1 initial values.
- With chaining on, the core starts from the digest it produced last.

Multi-block messages are therefore hashed by streaming blocks one after another. Message expansion is done on the fly inside the core. Padding and length encoding are left to the caller.

Top module: `sha1x2_core`

## Requirements
- R1: While and after reset, `busy_o` and `done_o` are low and `digest_o` is all zeros.
- R2: `start_i` high while `busy_o` is low makes `busy_o` high from the next cycle. `busy_o` stays high for exactly 41 consecutive cycles.
- R3: `done_o` is high for exactly one cycle, which is the first cycle after `busy_o` falls, and at no other time.
- R4: With `chain_i` low at start, the digest equals SHA-1 compression from 67452301 efcdab89 98badcfe 10325476 c3d2e1f0. For the one-block padded message "abc" it is a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.
- R5: Message word 0 is `block_i[511:480]` and word 15 is `block_i[31:0]`. In `digest_o`, word a sits in bits [159:128] and word e in bits [31:0].
- R6: With `chain_i` high at start, the previous digest is both the starting state and the value added at the end. For the padded 448-bit "abcdbcdecdefdefg..." message sent as two blocks, the result is 84983e44 1c3bd26e baae4aa1 f95129e5 e54670f1.
- R7: A start strobe that arrives while busy has no effect:
  - the running block, its chain choice and its timing are unchanged;
  - `block_i` and `chain_i` are sampled only when a start is accepted.
- R8: `digest_o` changes only in the cycle in which `done_o` is high. It holds while idle and while busy.
- R9: Every block value gives the correct digest. This includes the step groups 0–19, 20–39, 40–59 and 60–79, each with its own constant and selection function, and the look-ahead terms that cross group boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only while idle |
| chain_i | input | 1 | 1: start from the last digest; 0: start from the standard initial values |
| block_i | input | 512 | Padded message block, word 0 in the top bits |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle pulse when the digest is new |
| digest_o | output | 160 | Result, word a in the top bits |

## Verification
The core is run on several inputs, each separating a different fault:
- The "abc" block separates errors in the first step group, which has sparse message words.
- The two-block vector separates errors in the chaining path and in expansion over dense words.
- A block of all ones and a block of distinct counting words are run against a behavioural reference. They expose word-order swaps and wrong constants or functions at each 20-step boundary.
- A start pulse with a different block and chain setting injected mid-run shows whether the running computation is disturbed.

The cycle pattern of busy, done and digest is compared against a reference timeline on every clock.

// File: rtl/sha1x2_pkg.sv
// Shared constants, phase type and step functions of the two-step SHA-1 core.
// Assumes a 32-bit word and 80 steps; the step index is 7 bits and may
// exceed 79 on discarded look-ahead terms, which fall into the last group.
package sha1x2_pkg;

    localparam int WORD_W    = 32;
    localparam int WIN_WORDS = 16;
    localparam int BLK_W     = WORD_W * WIN_WORDS;
    localparam int NUM_REGS  = 5;
    localparam int DIG_W     = WORD_W * NUM_REGS;
    localparam int STEPS     = 80;
    localparam int GROUP_LEN = 20;
    localparam int STEP_W    = 7;
    localparam int LAST_T    = STEPS - 2;

    localparam logic [DIG_W-1:0] IV = {32'h67452301, 32'hefcdab89, 32'h98badcfe,
                                       32'h10325476, 32'hc3d2e1f0};

    typedef enum logic [1:0] {PH_IDLE, PH_PREP, PH_RUN} phase_e;

    // Left rotate of one word.
    function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x,
                                               input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // Group number of a step index.
    function automatic int unsigned grp(input logic [STEP_W-1:0] s);
        if (int'(s) < GROUP_LEN)          return 0;
        else if (int'(s) < 2 * GROUP_LEN) return 1;
        else if (int'(s) < 3 * GROUP_LEN) return 2;
        else                              return 3;
    endfunction

    // Selection function of the group that step s belongs to.
    function automatic logic [WORD_W-1:0] f_fn(input logic [STEP_W-1:0] s,
                                               input logic [WORD_W-1:0] b,
                                               input logic [WORD_W-1:0] c,
                                               input logic [WORD_W-1:0] d);
        unique case (grp(s))
            0:       return (b & c) | (~b & d);
            2:       return (b & c) | (b & d) | (c & d);
            default: return b ^ c ^ d;
        endcase
    endfunction

    // Additive constant of the group that step s belongs to.
    function automatic logic [WORD_W-1:0] k_fn(input logic [STEP_W-1:0] s);
        unique case (grp(s))
            0:       return 32'h5a827999;
            1:       return 32'h6ed9eba1;
            2:       return 32'h8f1bbcdc;
            default: return 32'hca62c1d6;
        endcase
    endfunction

endpackage

// File: rtl/sha1x2_sched.sv
// Message schedule: a 16-word sliding window that advances two words a cycle.
// Assumes load and shift are never high together. After load the window base
// is word 0; each shift drops two words and appends two expanded words.
module sha1x2_sched
    import sha1x2_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic              shift_i,
    output logic [WORD_W-1:0] w0_o,
    output logic [WORD_W-1:0] w1_o,
    output logic [WORD_W-1:0] w2_o
);

    localparam int NEW_WORDS = 2;

    logic [WORD_W-1:0] win_q [WIN_WORDS];
    logic [WORD_W-1:0] exp_w [NEW_WORDS];

    // Two expanded words per cycle from taps 0, 2, 8 and 13 relative to each new word.
    for (genvar g = 0; g < NEW_WORDS; g++) begin : g_expand
        assign exp_w[g] = rotl(win_q[13+g] ^ win_q[8+g] ^ win_q[2+g] ^ win_q[g], 1);
    end

    // Load the block or slide the window by two words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_WORDS; i++) win_q[i] <= '0;
        end else if (load_i) begin
            for (int i = 0; i < WIN_WORDS; i++)
                win_q[i] <= blk_i[BLK_W-1-WORD_W*i -: WORD_W];
        end else if (shift_i) begin
            for (int i = 0; i < WIN_WORDS - NEW_WORDS; i++)
                win_q[i] <= win_q[i+NEW_WORDS];
            for (int g = 0; g < NEW_WORDS; g++)
                win_q[WIN_WORDS-NEW_WORDS+g] <= exp_w[g];
        end
    end

    assign w0_o = win_q[0];
    assign w1_o = win_q[1];
    assign w2_o = win_q[2];

endmodule

// File: rtl/sha1x2_precomp.sv
// Look-ahead stage: holds l, m and n for the double-step about to run.
// On the seed cycle it forms l0, m0 and n0 from the starting state and words
// 0..2. On each run cycle it forms the sums for step t+2 from the next state,
// using the constant and function of the step each term targets.
module sha1x2_precomp
    import sha1x2_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_i,
    input  logic              adv_i,
    input  logic [STEP_W-1:0] t_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [WORD_W-1:0] c_i,
    input  logic [WORD_W-1:0] d_i,
    input  logic [WORD_W-1:0] e_i,
    input  logic [WORD_W-1:0] bn_i,
    input  logic [WORD_W-1:0] cn_i,
    input  logic [WORD_W-1:0] dn_i,
    input  logic [WORD_W-1:0] en_i,
    input  logic [WORD_W-1:0] w0_i,
    input  logic [WORD_W-1:0] w1_i,
    input  logic [WORD_W-1:0] w2_i,
    output logic [WORD_W-1:0] l_o,
    output logic [WORD_W-1:0] m_o,
    output logic [WORD_W-1:0] n_o
);

    logic [STEP_W-1:0] t_p2, t_p3, t_p4;
    logic [WORD_W-1:0] l_d, m_d, n_d;
    logic [WORD_W-1:0] l_q, m_q, n_q;

    assign t_p2 = t_i + STEP_W'(2);
    assign t_p3 = t_i + STEP_W'(3);
    assign t_p4 = t_i + STEP_W'(4);

    // Select seed sums or look-ahead sums for the next double-step.
    always_comb begin
        if (seed_i) begin
            l_d = f_fn('0, b_i, c_i, d_i) + e_i + w0_i + k_fn('0);
            m_d = d_i + w1_i + k_fn(STEP_W'(1));
            n_d = w2_i + k_fn(STEP_W'(2));
        end else begin
            l_d = f_fn(t_p2, bn_i, cn_i, dn_i) + en_i + n_q;
            m_d = dn_i + w1_i + k_fn(t_p3);
            n_d = w2_i + k_fn(t_p4);
        end
    end

    // Capture the sums on seed and run cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '0;
            m_q <= '0;
            n_q <= '0;
        end else if (seed_i || adv_i) begin
            l_q <= l_d;
            m_q <= m_d;
            n_q <= n_d;
        end
    end

    assign l_o = l_q;
    assign m_o = m_q;
    assign n_o = n_q;

endmodule

// File: rtl/sha1x2_round.sv
// Double-step datapath (combinational): state at even step t to state at t+2.
// Assumes l and m hold the look-ahead sums for step t; f of step t+1 is used.
module sha1x2_round
    import sha1x2_pkg::*;
(
    input  logic [STEP_W-1:0] t_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [WORD_W-1:0] c_i,
    input  logic [WORD_W-1:0] l_i,
    input  logic [WORD_W-1:0] m_i,
    output logic [WORD_W-1:0] a_o,
    output logic [WORD_W-1:0] b_o,
    output logic [WORD_W-1:0] c_o,
    output logic [WORD_W-1:0] d_o,
    output logic [WORD_W-1:0] e_o
);

    logic [STEP_W-1:0] t_p1;
    logic [WORD_W-1:0] b30;

    assign t_p1 = t_i + STEP_W'(1);
    assign b30  = rotl(b_i, 30);

    // Two steps folded onto the pre-summed terms.
    always_comb begin
        b_o = rotl(a_i, 5) + l_i;
        a_o = rotl(b_o, 5) + f_fn(t_p1, a_i, b30, c_i) + m_i;
        c_o = rotl(a_i, 30);
        d_o = b30;
        e_o = c_i;
    end

endmodule

// File: rtl/sha1x2_core.sv
// Top of the two-step SHA-1 compression core. It takes a start while idle,
// spends one seed cycle and forty double-step cycles, then adds the final
// state to the starting chain words. Assumes the block is already padded.
module sha1x2_core
    import sha1x2_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              chain_i,
    input  logic [BLK_W-1:0]  block_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DIG_W-1:0]  digest_o
);

    phase_e            ph_q;
    logic [STEP_W-1:0] t_q;
    logic [WORD_W-1:0] a_q, b_q, c_q, d_q, e_q;
    logic [WORD_W-1:0] a_n, b_n, c_n, d_n, e_n;
    logic [WORD_W-1:0] l_w, m_w, n_w;
    logic [WORD_W-1:0] w0, w1, w2;
    logic [DIG_W-1:0]  hv_q, dig_q, start_h, sum_h;
    logic              done_q, accept, in_prep, in_run, last_run;

    assign accept   = start_i && (ph_q == PH_IDLE);
    assign in_prep  = (ph_q == PH_PREP);
    assign in_run   = (ph_q == PH_RUN);
    assign last_run = in_run && (t_q == STEP_W'(LAST_T));
    assign start_h  = chain_i ? dig_q : IV;

    sha1x2_sched u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .blk_i   (block_i),
        .shift_i (in_prep || in_run),
        .w0_o    (w0),
        .w1_o    (w1),
        .w2_o    (w2)
    );

    sha1x2_precomp u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed_i (in_prep),
        .adv_i  (in_run),
        .t_i    (t_q),
        .b_i    (b_q),
        .c_i    (c_q),
        .d_i    (d_q),
        .e_i    (e_q),
        .bn_i   (b_n),
        .cn_i   (c_n),
        .dn_i   (d_n),
        .en_i   (e_n),
        .w0_i   (w0),
        .w1_i   (w1),
        .w2_i   (w2),
        .l_o    (l_w),
        .m_o    (m_w),
        .n_o    (n_w)
    );

    sha1x2_round u_round (
        .t_i (t_q),
        .a_i (a_q),
        .b_i (b_q),
        .c_i (c_q),
        .l_i (l_w),
        .m_i (m_w),
        .a_o (a_n),
        .b_o (b_n),
        .c_o (c_n),
        .d_o (d_n),
        .e_o (e_n)
    );

    // Final feed-forward: each next-state word plus its chain word.
    assign sum_h = {a_n + hv_q[4*WORD_W +: WORD_W], b_n + hv_q[3*WORD_W +: WORD_W],
                    c_n + hv_q[2*WORD_W +: WORD_W], d_n + hv_q[WORD_W +: WORD_W],
                    e_n + hv_q[0 +: WORD_W]};

    // Phase sequencing and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
            t_q  <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: if (accept) ph_q <= PH_PREP;
                PH_PREP: begin
                    ph_q <= PH_RUN;
                    t_q  <= '0;
                end
                PH_RUN: begin
                    t_q <= t_q + STEP_W'(2);
                    if (last_run) ph_q <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Working words: load the chain words on accept, advance two steps per run cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {a_q, b_q, c_q, d_q, e_q} <= '0;
            hv_q <= '0;
        end else if (accept) begin
            {a_q, b_q, c_q, d_q, e_q} <= start_h;
            hv_q <= start_h;
        end else if (in_run) begin
            {a_q, b_q, c_q, d_q, e_q} <= {a_n, b_n, c_n, d_n, e_n};
        end
    end

    // Digest register and one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dig_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last_run;
            if (last_run) dig_q <= sum_h;
        end
    end

    assign busy_o   = (ph_q != PH_IDLE);
    assign done_o   = done_q;
    assign digest_o = dig_q;

endmodule

// File: rtl/sha1x2_core_chk.sv
// Property checker for sha1x2_core, attached by bind. It observes ports only
// and keeps its own count of busy cycles.
module sha1x2_core_chk
    import sha1x2_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [DIG_W-1:0] digest_o
);

    logic [STEP_W-1:0] busy_cnt;

    // Count consecutive busy cycles, starting at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) busy_cnt <= '0;
        else                   busy_cnt <= busy_cnt + STEP_W'(1);
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!busy_o && !done_o && digest_o == '0)); // R1
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> busy_o); // R2
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> busy_cnt <= STEP_W'(40)); // R2
    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> $past(busy_cnt) == STEP_W'(40)); // R2
    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> ($past(busy_o) && !busy_o)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && start_i && busy_cnt != STEP_W'(40)) |=> (busy_o && !done_o)); // R7
    AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rst_n |=> (done_o || $stable(digest_o))); // R8

endmodule

bind sha1x2_core sha1x2_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .digest_o (digest_o)
);

// File: tb/sha1x2_core_tb_top.sv
// Self-checking bench: behavioural SHA-1 reference plus a per-clock timeline.
module sha1x2_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [159:0] IV_W  = {32'h67452301, 32'hefcdab89, 32'h98badcfe,
                                      32'h10325476, 32'hc3d2e1f0};
    localparam logic [159:0] ABC_D = 160'ha9993e364706816aba3e25717850c26c9cd0d89d;
    localparam logic [159:0] TWO_D = 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         chain_i = 1'b0;
    logic [511:0] block_i = '0;
    logic         busy_o, done_o;
    logic [159:0] digest_o;

    int checks = 0;
    int fails  = 0;
    logic [159:0] model_dig = '0;

    sha1x2_core dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .chain_i  (chain_i),
        .block_i  (block_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .digest_o (digest_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Plain 80-step SHA-1 compression, word 0 taken from the top bits (R5).
    function automatic logic [159:0] ref_compress(input logic [159:0] h, input logic [511:0] blk);
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, tmp;
        for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
        for (int i = 16; i < 80; i++) begin
            logic [31:0] x;
            x = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
            w[i] = {x[30:0], x[31]};
        end
        {a, b, c, d, e} = h;
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5a827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ed9eba1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8f1bbcdc; end
            else             begin f = b ^ c ^ d;                   k = 32'hca62c1d6; end
            tmp = {a[26:0], a[31:27]} + f + e + k + w[i];
            e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = tmp;
        end
        return {a + h[159:128], b + h[127:96], c + h[95:64], d + h[63:32], e + h[31:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One block: start at a falling edge, then compare busy/done/digest every clock.
    task automatic run_block(input logic [511:0] blk, input bit cont, input bit inject,
                             input string tag, input logic [159:0] known, input bit use_known);
        logic [159:0] exp_d;
        exp_d = ref_compress(cont ? model_dig : IV_W, blk);
        @(negedge clk);
        start_i = 1'b1; block_i = blk; chain_i = cont;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k <= 41; k++) begin
            chk(busy_o && !done_o, "R2 busy window", {158'd0, busy_o, done_o}, 160'd2);
            chk(digest_o == model_dig, "R8 digest held while busy", digest_o, model_dig);
            if (inject && k == 10) begin
                start_i = 1'b1; block_i = ~blk; chain_i = ~cont;   // R7 stray start
            end
            if (inject && k == 11) start_i = 1'b0;
            @(negedge clk);
        end
        chk(!busy_o && done_o, "R3 done at busy fall", {158'd0, busy_o, done_o}, 160'd1);
        chk(digest_o == exp_d, tag, digest_o, exp_d);
        if (use_known) chk(digest_o == known, tag, digest_o, known);
        model_dig = exp_d;
        @(negedge clk);
        chk(!done_o, "R3 done one cycle", {159'd0, done_o}, 160'd0);
        chk(digest_o == model_dig, "R8 digest held after done", digest_o, model_dig);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [511:0] abc, two_a, two_b, ones, cnt_blk;
        abc   = {32'h61626380, 416'd0, 32'h00000000, 32'h00000018};
        two_a = {32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
                 32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
                 32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
                 32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
        two_b = {480'd0, 32'h000001c0};
        ones  = '1;
        for (int i = 0; i < 16; i++) cnt_blk[511-32*i -: 32] = 32'h01020304 * (i + 1);

        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && digest_o == '0, "R1 during reset", digest_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && digest_o == '0, "R1 after reset", digest_o, '0);

        run_block(abc, 1'b0, 1'b0, "R4 abc digest", ABC_D, 1'b1);
        run_block(two_a, 1'b0, 1'b0, "R6 first block", '0, 1'b0);
        run_block(two_b, 1'b1, 1'b0, "R6 chained digest", TWO_D, 1'b1);
        run_block(abc, 1'b0, 1'b1, "R7 start ignored while busy", ABC_D, 1'b1);
        run_block(ones, 1'b1, 1'b0, "R9 all-ones chained", '0, 1'b0);
        run_block(cnt_blk, 1'b0, 1'b0, "R5 word order", '0, 1'b0);
        run_block(cnt_blk ^ {16{32'h5a5aa5a5}}, 1'b0, 1'b0, "R9 mixed pattern", '0, 1'b0);

        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!busy_o && !done_o && digest_o == model_dig, "R8 idle hold", digest_o, model_dig);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule